// File: doc/BRIEF.md
# Signed Carry-Save Reduction Multiplier

This block multiplies two signed two's-complement operands of `W` bits (six by default) and returns the full `2W`-bit signed product. Each bit of the second operand gates one shifted copy of the first operand, which gives `W` rows of partial products.

Rows are not widened with copies of their sign bits. Instead, every bit whose weight involves exactly one operand MSB is inverted, and two constant ones are injected into the matrix. The resulting bit matrix is compressed one column at a time by a chain of carry-save stages. Each stage lowers every column to a fixed ceiling taken from the series 2, 3, 4, 6, 9, 13, 19, …, where each term is the previous one times 3/2, rounded down. A stage places a full adder wherever a column must lose two bits, and a half adder only where it must lose exactly one.

A single carry-propagate adder turns the last two rows into the product. By default the product and a valid flag pass through one output register that loads only when the input is flagged valid. With `OUT_REG` cleared, the path is purely combinational.

Top module: `smul_top`

## Requirements
- R1: For every pair of operands taken as signed `W`-bit integers, `prod_o` equals their exact product as a signed `2W`-bit value, one clock after `valid_i` was high.
- R2: The most negative operand times itself gives +2^(2W-2), which is 1024 for `W`=6, with the product MSB at 0.
- R3: If either operand is zero, the product is zero.
- R4: `valid_o` equals `valid_i` of the previous clock edge.
- R5: On an edge where `valid_i` is low, `prod_o` keeps its previous value, whatever the operands are.
- R6: While `rst_ni` is low, `valid_o` is 0 and `prod_o` is all zeros, even if `valid_i` is high.
- R7: When both operands are nonzero, the product MSB (bit `2W-1`) equals the XOR of the two operand MSBs.
- R8: Multiplying by +1 returns the other operand sign-extended to `2W` bits. Multiplying by -1 (all ones) returns its two's-complement negation, including -2^(W-1) × -1 = +2^(W-1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands are valid this cycle |
| a_i | input | W | Multiplicand, two's complement |
| b_i | input | W | Multiplier, two's complement |
| valid_o | output | 1 | Product is valid |
| prod_o | output | 2W | Signed product |

## Verification
The bound checker evaluates on every edge the following: the one-cycle delay of the valid flag, the product against a signed reference whenever a valid operand pair was captured, the zero-operand and sign-bit rules, the hold of the product on cycles without valid input, and the cleared outputs during reset. Only the bench's scenarios show full coverage of the product function: a sweep over all 4096 operand pairs, the explicit extremes at -32, +1 and -1, and the fact that operands and valid presented during reset leave no trace.

// File: rtl/smul_pkg.sv
package smul_pkg;

  localparam int MAX_COLS = 64;

  localparam int SEL_HEIGHT   = 0;
  localparam int SEL_CARRY_IN = 1;
  localparam int SEL_FULL     = 2;
  localparam int SEL_HALF     = 3;

  // number of matrix bits in column c, constants included
  function automatic int pp_height(input int w, input int c);
    int n;
    n = 0;
    for (int i = 0; i < w; i++)
      if (c >= i && c <= i + w - 1) n++;
    if (c == w || c == 2 * w - 1) n++;
    return n;
  endfunction

  function automatic int pp_max_height(input int w);
    int m;
    m = 0;
    for (int c = 0; c < 2 * w; c++)
      if (pp_height(w, c) > m) m = pp_height(w, c);
    return m;
  endfunction

  // number of targets in 2,3,4,6,9,.. below the initial height
  function automatic int stage_count(input int w);
    int d;
    int m;
    int hm;
    d  = 2;
    m  = 0;
    hm = pp_max_height(w);
    while (d < hm) begin
      m++;
      d = d * 3 / 2;
    end
    return m;
  endfunction

  function automatic int stage_target(input int w, input int s);
    int d;
    d = 2;
    for (int k = 1; k < stage_count(w) - s; k++) d = d * 3 / 2;
    return d;
  endfunction

  // replays the reduction schedule up to stage s and reports column c
  function automatic int col_info(input int w, input int s, input int c, input int sel);
    int h [MAX_COLS];
    int carry;
    int n;
    int d;
    int r;
    int nf;
    int nh;
    int res;
    res = 0;
    for (int k = 0; k < MAX_COLS; k++) h[k] = (k < 2 * w) ? pp_height(w, k) : 0;
    for (int st = 0; st <= s; st++) begin
      d     = stage_target(w, st);
      carry = 0;
      for (int col = 0; col < 2 * w; col++) begin
        n  = h[col] + carry;
        r  = (n > d) ? n - d : 0;
        nf = r / 2;
        nh = r % 2;
        if (st == s && col == c) begin
          if (sel == SEL_HEIGHT)        res = h[col];
          else if (sel == SEL_CARRY_IN) res = carry;
          else if (sel == SEL_FULL)     res = nf;
          else                          res = nh;
        end
        h[col] = n - 2 * nf - nh;
        carry  = nf + nh;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/smul_counter.sv
module smul_counter #(
  parameter bit FULL = 1'b1
) (
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output logic sum_o,
  output logic carry_o
);

  if (FULL) begin : g_full
    assign sum_o   = x_i ^ y_i ^ z_i;
    assign carry_o = (x_i & y_i) | (z_i & (x_i ^ y_i));
  end else begin : g_half
    logic unused_z;
    assign unused_z = z_i;
    assign sum_o    = x_i ^ y_i;
    assign carry_o  = x_i & y_i;
  end

endmodule

// File: rtl/smul_ppgen.sv
module smul_ppgen
  import smul_pkg::*;
#(
  parameter int W    = 6,
  parameter int MAXH = 8
) (
  input  logic [W-1:0]                a_i,
  input  logic [W-1:0]                b_i,
  output logic [2*W-1:0][MAXH-1:0]    mat_o
);

  localparam int COLS = 2 * W;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam bit HAS_ONE = (c == W) || (c == COLS - 1);
    localparam int LO      = (c > W - 1) ? c - W + 1 : 0;
    localparam int NR      = pp_height(W, c) - (HAS_ONE ? 1 : 0);
    for (genvar j = 0; j < MAXH; j++) begin : g_bit
      if (j < NR) begin : g_pp
        localparam int RI = LO + j;
        localparam int CI = c - RI;
        // weight carries exactly one operand MSB: store the complement
        localparam bit INV = (RI == W - 1) != (CI == W - 1);
        assign mat_o[c][j] = (a_i[CI] & b_i[RI]) ^ INV;
      end else if (j == NR && HAS_ONE) begin : g_one
        assign mat_o[c][j] = 1'b1;
      end else begin : g_nil
        assign mat_o[c][j] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/smul_csa_stage.sv
module smul_csa_stage
  import smul_pkg::*;
#(
  parameter int W    = 6,
  parameter int S    = 0,
  parameter int MAXH = 8
) (
  input  logic [2*W-1:0][MAXH-1:0] mat_i,
  output logic [2*W-1:0][MAXH-1:0] mat_o
);

  localparam int COLS = 2 * W;
  localparam int LMAX = 2 * MAXH;

  logic [COLS-1:0][LMAX-1:0] lst;
  logic [COLS-1:0][MAXH-1:0] cy;
  logic [COLS-1:0][MAXH-1:0] sm;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int HI   = col_info(W, S, c, SEL_HEIGHT);
    localparam int CIN  = col_info(W, S, c, SEL_CARRY_IN);
    localparam int NF   = col_info(W, S, c, SEL_FULL);
    localparam int NH   = col_info(W, S, c, SEL_HALF);
    localparam int NC   = NF + NH;
    localparam int NI   = HI + CIN;
    localparam int HO   = NI - NF - NC;
    localparam int USED = 3 * NF + 2 * NH;

    // column list: own bits first, then carries from the column below
    for (genvar j = 0; j < LMAX; j++) begin : g_lst
      if (j < HI) begin : g_own
        assign lst[c][j] = mat_i[c][j];
      end else if (j < NI) begin : g_cin
        assign lst[c][j] = cy[c-1][j-HI];
      end else begin : g_nil
        assign lst[c][j] = 1'b0;
      end
    end

    for (genvar k = 0; k < MAXH; k++) begin : g_cnt
      if (k < NF) begin : g_fa
        smul_counter #(.FULL(1'b1)) u_cnt (
          .x_i    (lst[c][3*k]),
          .y_i    (lst[c][3*k+1]),
          .z_i    (lst[c][3*k+2]),
          .sum_o  (sm[c][k]),
          .carry_o(cy[c][k])
        );
      end else if (k < NC) begin : g_ha
        smul_counter #(.FULL(1'b0)) u_cnt (
          .x_i    (lst[c][3*NF]),
          .y_i    (lst[c][3*NF+1]),
          .z_i    (1'b0),
          .sum_o  (sm[c][k]),
          .carry_o(cy[c][k])
        );
      end else begin : g_none
        assign sm[c][k] = 1'b0;
        assign cy[c][k] = 1'b0;
      end
    end

    for (genvar j = 0; j < MAXH; j++) begin : g_out
      if (j < NC) begin : g_sum
        assign mat_o[c][j] = sm[c][j];
      end else if (j < HO) begin : g_pass
        assign mat_o[c][j] = lst[c][USED+j-NC];
      end else begin : g_nil
        assign mat_o[c][j] = 1'b0;
      end
    end
  end

  // spare slots and the top column's carries are left open
  logic unused_bits;
  assign unused_bits = ^{mat_i, lst, cy, sm};

endmodule

// File: rtl/smul_cpa.sv
module smul_cpa #(
  parameter int W    = 6,
  parameter int MAXH = 8
) (
  input  logic [2*W-1:0][MAXH-1:0] mat_i,
  output logic [2*W-1:0]           sum_o
);

  localparam int COLS = 2 * W;

  logic [COLS-1:0] row_x;
  logic [COLS-1:0] row_y;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign row_x[c] = mat_i[c][0];
    assign row_y[c] = mat_i[c][1];
  end

  // carry out of the top column is dropped: result is modulo 2^(2W)
  assign sum_o = row_x + row_y;

  logic unused_bits;
  assign unused_bits = ^mat_i;

endmodule

// File: rtl/smul_top.sv
module smul_top
  import smul_pkg::*;
#(
  parameter int W       = 6,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           valid_o,
  output logic [2*W-1:0] prod_o
);

  localparam int COLS = 2 * W;
  localparam int MAXH = W + 2;
  localparam int NS   = stage_count(W);

  logic [NS:0][COLS-1:0][MAXH-1:0] mat;
  logic [COLS-1:0]                 prod_c;

  smul_ppgen #(.W(W), .MAXH(MAXH)) u_ppgen (
    .a_i  (a_i),
    .b_i  (b_i),
    .mat_o(mat[0])
  );

  for (genvar s = 0; s < NS; s++) begin : g_stage
    smul_csa_stage #(.W(W), .S(s), .MAXH(MAXH)) u_stage (
      .mat_i(mat[s]),
      .mat_o(mat[s+1])
    );
  end

  smul_cpa #(.W(W), .MAXH(MAXH)) u_cpa (
    .mat_i(mat[NS]),
    .sum_o(prod_c)
  );

  if (OUT_REG) begin : g_reg
    logic            valid_q;
    logic [COLS-1:0] prod_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        prod_q  <= '0;
      end else begin
        valid_q <= valid_i;
        if (valid_i) prod_q <= prod_c;
      end
    end
    assign valid_o = valid_q;
    assign prod_o  = prod_q;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign valid_o    = valid_i;
    assign prod_o     = prod_c;
  end

endmodule

// File: rtl/smul_top_chk.sv
module smul_top_chk #(
  parameter int W       = 6,
  parameter bit OUT_REG = 1'b1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           valid_i,
  input logic [W-1:0]   a_i,
  input logic [W-1:0]   b_i,
  input logic           valid_o,
  input logic [2*W-1:0] prod_o
);

  logic signed [2*W-1:0] exp_c;
  assign exp_c = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});

  if (OUT_REG) begin : g_seq
    // R1
    a_r1_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> prod_o == $past(exp_c));

    // R3
    a_r3_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && (a_i == '0 || b_i == '0)) |=> prod_o == '0);

    // R4
    a_r4_valid_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    a_r4_valid_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);

    // R5
    a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(prod_o));

    // R7
    a_r7_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && a_i != '0 && b_i != '0) |=> prod_o[2*W-1] == $past(a_i[W-1] ^ b_i[W-1]));

    // R6
    always @(negedge clk_i) begin
      if (!rst_ni) begin
        a_r6_reset: assert (!valid_o && prod_o == '0);
      end
    end
  end else begin : g_comb
    logic unused_rst;
    assign unused_rst = rst_ni;
    always @(negedge clk_i) begin
      a_r1_comb_product: assert (prod_o == exp_c);
      a_r4_comb_valid: assert (valid_o == valid_i);
    end
  end

endmodule

bind smul_top smul_top_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .valid_o(valid_o),
  .prod_o (prod_o)
);

// File: tb/smul_top_test.sv
module smul_top_test;

  localparam int W  = 6;
  localparam int PW = 2 * W;

  logic          clk_i   = 1'b0;
  logic          rst_ni  = 1'b0;
  logic          valid_i = 1'b0;
  logic [W-1:0]  a_i     = '0;
  logic [W-1:0]  b_i     = '0;
  logic          valid_o;
  logic [PW-1:0] prod_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  smul_top #(.W(W), .OUT_REG(1'b1)) uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .valid_o(valid_o),
    .prod_o (prod_o)
  );

  function automatic int to_int(input logic [W-1:0] v);
    return v[W-1] ? int'(v) - (1 << W) : int'(v);
  endfunction

  function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] x, input logic [W-1:0] y);
    return PW'(to_int(x) * to_int(y));
  endfunction

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive between edges, sample just after the capturing edge
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic v);
    @(negedge clk_i);
    a_i     = a;
    b_i     = b;
    valid_i = v;
    @(posedge clk_i);
    #1;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    logic [PW-1:0] held;

    // R6: inputs during reset must not reach the outputs
    @(negedge clk_i);
    a_i = 6'd5; b_i = 6'd3; valid_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    check("R6 valid_o in reset", PW'(valid_o), '0);
    check("R6 prod_o in reset", prod_o, '0);
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni  = 1'b1;
    @(posedge clk_i);
    #1;
    check("R4 idle after reset", PW'(valid_o), '0);

    // R1 exhaustive sweep with tags for the special classes
    for (int ai = 0; ai < (1 << W); ai++) begin
      for (int bi = 0; bi < (1 << W); bi++) begin
        logic [W-1:0] a;
        logic [W-1:0] b;
        a = W'(ai);
        b = W'(bi);
        apply(a, b, 1'b1);
        if (a == '0 || b == '0)
          check("R3 zero operand", prod_o, '0);
        else if (a == {1'b1, {(W-1){1'b0}}} && b == a)
          check("R2 min times min", prod_o, PW'(1 << (2 * W - 2)));
        else
          check("R1 product", prod_o, ref_mul(a, b));
        if (a != '0 && b != '0)
          check("R7 sign bit", PW'(prod_o[PW-1]), PW'((to_int(a) < 0) ^ (to_int(b) < 0)));
      end
    end
    check("R4 valid after sweep", PW'(valid_o), PW'(1));

    // R8 identities at the edges
    apply(6'd31, 6'd1, 1'b1);
    check("R8 times plus one", prod_o, PW'(31));
    apply(6'b100000, 6'd1, 1'b1);
    check("R8 min times plus one", prod_o, {{(W+1){1'b1}}, {(W-1){1'b0}}});
    apply(6'd13, 6'b111111, 1'b1);
    check("R8 times minus one", prod_o, PW'(-13));
    apply(6'b100000, 6'b111111, 1'b1);
    check("R8 min times minus one", prod_o, PW'(32));

    // R5 and R4: hold when not valid
    apply(6'd7, 6'd9, 1'b1);
    check("R5 load", prod_o, PW'(63));
    held = prod_o;
    apply(6'd20, 6'b111101, 1'b0);
    check("R5 hold product", prod_o, held);
    check("R4 valid low", PW'(valid_o), '0);
    apply(6'b100000, 6'b100000, 1'b0);
    check("R5 hold second", prod_o, held);
    apply(6'b100000, 6'b100000, 1'b1);
    check("R4 valid high", PW'(valid_o), PW'(1));
    check("R2 after hold", prod_o, PW'(1024));

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1: actual=timeout expected=completion");
      report();
      $finish;
    end
  end

endmodule